// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block drives the timing side of a TFT LCD panel. It divides its own clock by a programmable value to get a one-cycle pixel step, and from that step it walks two state machines. The horizontal machine lays out each line as a sync pulse, a back porch, the active pixels and a front porch. The vertical machine lays out each frame in the same way, counted in whole lines. It produces the sync pulses, the data enable, the position of the current pixel inside the active area, and pixel data. Each of these has its own polarity-invert bit.

Software sets the block up through a simple write port, one register per address. The timing registers are copied into shadow registers only at the start of a frame, so a frame that is already under way keeps its geometry. A two-bit mode field turns the block off or selects what the pixel bus carries. In colour-bar mode the active width is split into eight vertical bands, and each band has its own programmable colour.

Horizontal states: `H_IDLE`, `H_SYNC`, `H_BACK`, `H_ACTIVE`, `H_FRONT`. The transitions are `H_IDLE`→`H_SYNC` when the mode becomes non-zero, then `H_SYNC`→`H_BACK`→`H_ACTIVE`→`H_FRONT`→`H_SYNC`. Each of these moves happens on the pixel step that ends the current segment. Every state falls back to `H_IDLE` when the mode is 00. The vertical states `V_IDLE`, `V_SYNC`, `V_BACK`, `V_ACTIVE`, `V_FRONT` follow the same ring, but they advance only on the pixel step that ends a line (the last step of `H_FRONT`).

Top module: `lcd_timing_gen`

## Requirements
- R1: Each line is, in pixel steps: sync active for the sync width (address 2), back porch (address 3), the active width (address 1) with data enable high when the line is also vertically active, then the front porch (address 4), then the next sync.
- R2: Each frame is, in lines: vertical sync active for the vertical sync width (address 6), back porch (address 7), the active height (address 5), then the front porch (address 8).
- R3: A value of 0 in any of the timing registers at addresses 1 to 8 is used as 1.
- R4: A pixel step occurs once every D block clocks, where D is address 9 (6 bits) clamped into 2..32. One frame therefore spans D × (width+sync+back+front) × (height+vsync+vback+vfront) block clocks.
- R5: Address 10 holds the invert bits: bit 0 horizontal sync, bit 1 vertical sync, bit 2 data enable, bit 3 all 24 pixel data bits. Every output is active-high when its bit is 0.
- R6: Mode is address 0, bits [1:0]. From the clock edge after the mode register reads 00, every output sits at its inactive level after inversion, and both positions read 0. Writing a non-zero mode restarts at the first sync pixel of a frame on the next edge.
- R7: In mode 11 the pixel data during data enable is the colour of band k (address 16+k, 24 bits). Each band is max(width/8,1) pixels wide, and pixels left over fall in band 7. In modes 01 and 10 the data is 0. Outside data enable the data is 0 before inversion.
- R8: Writes to addresses 1 to 9 take effect only from the next frame start. The frame in progress keeps its length.
- R9: The X output is the pixel index inside the active width while the horizontal machine is in its active segment, and 0 otherwise. The Y output is the line index inside the active height in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after inversion |
| vsync_o | output | 1 | Vertical sync after inversion |
| de_o | output | 1 | Data enable after inversion |
| pix_x_o | output | 12 | Active pixel column |
| pix_y_o | output | 12 | Active line |
| pix_data_o | output | 24 | Pixel data after inversion |

## Verification
A register write lands on the rising edge that samples the strobe. A change of mode moves the state machines one edge later. Writes to the timing registers appear only at the next frame wrap, and counters move only on the pixel step that comes every D clocks. The outputs are decoded directly from registered state, so they settle right after the edge that changes that state. The bench model steps a linear line and frame position on each rising edge, using the register values from before the write that the same edge samples. It compares every output at the falling edge that follows. Frame lengths are measured between rising edges of the vertical sync, and these cover R3, R4 and R8 as exact clock counts.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [2:0] {
        H_IDLE,
        H_SYNC,
        H_BACK,
        H_ACTIVE,
        H_FRONT
    } hstate_t;

    typedef enum logic [2:0] {
        V_IDLE,
        V_SYNC,
        V_BACK,
        V_ACTIVE,
        V_FRONT
    } vstate_t;

    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_BARS = 2'b11;

    localparam int ADR_MODE  = 0;
    localparam int ADR_HACT  = 1;
    localparam int ADR_HSW   = 2;
    localparam int ADR_HBP   = 3;
    localparam int ADR_HFP   = 4;
    localparam int ADR_VACT  = 5;
    localparam int ADR_VSW   = 6;
    localparam int ADR_VBP   = 7;
    localparam int ADR_VFP   = 8;
    localparam int ADR_DIV   = 9;
    localparam int ADR_POL   = 10;
    localparam int ADR_BAND0 = 16;

    localparam int POL_HS   = 0;
    localparam int POL_VS   = 1;
    localparam int POL_DE   = 2;
    localparam int POL_DATA = 3;

endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
    import lcdt_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int PS_W    = 6,
    parameter int COL_W   = 24,
    parameter int NBANDS  = 8,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      load_i,
    output logic [1:0]                mode_o,
    output logic [3:0]                pol_o,
    output logic [NBANDS*COL_W-1:0]   colours_o,
    output logic [CNT_W-1:0]          sh_hact_o,
    output logic [CNT_W-1:0]          sh_hsw_o,
    output logic [CNT_W-1:0]          sh_hbp_o,
    output logic [CNT_W-1:0]          sh_hfp_o,
    output logic [CNT_W-1:0]          sh_vact_o,
    output logic [CNT_W-1:0]          sh_vsw_o,
    output logic [CNT_W-1:0]          sh_vbp_o,
    output logic [CNT_W-1:0]          sh_vfp_o,
    output logic [PS_W-1:0]           sh_div_o
);

    logic [CNT_W-1:0] hact_q, hsw_q, hbp_q, hfp_q;
    logic [CNT_W-1:0] vact_q, vsw_q, vbp_q, vfp_q;
    logic [PS_W-1:0]  div_q;
    logic [1:0]       mode_q;
    logic [3:0]       pol_q;
    logic             unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:COL_W];

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic logic [PS_W-1:0] div_clamp(input logic [PS_W-1:0] v);
        if (v < PS_W'(DIV_MIN)) return PS_W'(DIV_MIN);
        if (v > PS_W'(DIV_MAX)) return PS_W'(DIV_MAX);
        return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            pol_q  <= '0;
            hact_q <= '0;
            hsw_q  <= '0;
            hbp_q  <= '0;
            hfp_q  <= '0;
            vact_q <= '0;
            vsw_q  <= '0;
            vbp_q  <= '0;
            vfp_q  <= '0;
            div_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(ADR_MODE): mode_q <= wr_data[1:0];
                ADDR_W'(ADR_POL):  pol_q  <= wr_data[3:0];
                ADDR_W'(ADR_HACT): hact_q <= wr_data[CNT_W-1:0];
                ADDR_W'(ADR_HSW):  hsw_q  <= wr_data[CNT_W-1:0];
                ADDR_W'(ADR_HBP):  hbp_q  <= wr_data[CNT_W-1:0];
                ADDR_W'(ADR_HFP):  hfp_q  <= wr_data[CNT_W-1:0];
                ADDR_W'(ADR_VACT): vact_q <= wr_data[CNT_W-1:0];
                ADDR_W'(ADR_VSW):  vsw_q  <= wr_data[CNT_W-1:0];
                ADDR_W'(ADR_VBP):  vbp_q  <= wr_data[CNT_W-1:0];
                ADDR_W'(ADR_VFP):  vfp_q  <= wr_data[CNT_W-1:0];
                ADDR_W'(ADR_DIV):  div_q  <= wr_data[PS_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NBANDS; g++) begin : g_band
        logic [COL_W-1:0] col_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                col_q <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(ADR_BAND0 + g)) begin
                col_q <= wr_data[COL_W-1:0];
            end
        end
        assign colours_o[g*COL_W +: COL_W] = col_q;
    end

    // Shadow copies: refreshed while idle and at each frame wrap only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_hact_o <= CNT_W'(1);
            sh_hsw_o  <= CNT_W'(1);
            sh_hbp_o  <= CNT_W'(1);
            sh_hfp_o  <= CNT_W'(1);
            sh_vact_o <= CNT_W'(1);
            sh_vsw_o  <= CNT_W'(1);
            sh_vbp_o  <= CNT_W'(1);
            sh_vfp_o  <= CNT_W'(1);
            sh_div_o  <= PS_W'(DIV_MIN);
        end else if (load_i) begin
            sh_hact_o <= at_least_one(hact_q);
            sh_hsw_o  <= at_least_one(hsw_q);
            sh_hbp_o  <= at_least_one(hbp_q);
            sh_hfp_o  <= at_least_one(hfp_q);
            sh_vact_o <= at_least_one(vact_q);
            sh_vsw_o  <= at_least_one(vsw_q);
            sh_vbp_o  <= at_least_one(vbp_q);
            sh_vfp_o  <= at_least_one(vfp_q);
            sh_div_o  <= div_clamp(div_q);
        end
    end

    assign mode_o = mode_q;
    assign pol_o  = pol_q;

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(sh_hact_o) && $stable(sh_hsw_o) && $stable(sh_hbp_o) &&
                     $stable(sh_hfp_o) && $stable(sh_vact_o) && $stable(sh_vfp_o) &&
                     $stable(sh_div_o)));

    assert_porch_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_hbp_o != '0) && (sh_hfp_o != '0) && (sh_vbp_o != '0) && (sh_vfp_o != '0));

endmodule

// File: rtl/lcdt_prescale.sv
module lcdt_prescale #(
    parameter int PS_W    = 6,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [PS_W-1:0] div_i,
    output logic            pix_en_o
);

    logic [PS_W-1:0] cnt_q;
    logic            wrap;

    assign wrap     = (cnt_q == div_i - PS_W'(1));
    assign pix_en_o = run_i && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PS_W'(1);
        end
    end

    assert_en_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en_o |=> !pix_en_o);

    assert_div_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i >= PS_W'(DIV_MIN)) && (div_i <= PS_W'(DIV_MAX)));

endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
    import lcdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             pix_en_i,
    input  logic [CNT_W-1:0] hact_i,
    input  logic [CNT_W-1:0] hsw_i,
    input  logic [CNT_W-1:0] hbp_i,
    input  logic [CNT_W-1:0] hfp_i,
    input  logic [CNT_W-1:0] vact_i,
    input  logic [CNT_W-1:0] vsw_i,
    input  logic [CNT_W-1:0] vbp_i,
    input  logic [CNT_W-1:0] vfp_i,
    output hstate_t          hstate_o,
    output vstate_t          vstate_o,
    output logic [CNT_W-1:0] hcnt_o,
    output logic [CNT_W-1:0] vcnt_o,
    output logic             scanning_o,
    output logic             frame_end_o
);

    hstate_t          h_q, h_d;
    vstate_t          v_q, v_d;
    logic [CNT_W-1:0] hcnt_q, hcnt_d, vcnt_q, vcnt_d;
    logic [CNT_W-1:0] h_len, v_len;
    logic             h_last, line_end, v_last;

    always_comb begin
        unique case (h_q)
            H_SYNC:   h_len = hsw_i;
            H_BACK:   h_len = hbp_i;
            H_ACTIVE: h_len = hact_i;
            H_FRONT:  h_len = hfp_i;
            default:  h_len = CNT_W'(1);
        endcase
        unique case (v_q)
            V_SYNC:   v_len = vsw_i;
            V_BACK:   v_len = vbp_i;
            V_ACTIVE: v_len = vact_i;
            V_FRONT:  v_len = vfp_i;
            default:  v_len = CNT_W'(1);
        endcase
    end

    assign h_last   = pix_en_i && (hcnt_q == h_len - CNT_W'(1));
    assign line_end = h_last && (h_q == H_FRONT);
    assign v_last   = line_end && (vcnt_q == v_len - CNT_W'(1));

    // Horizontal next state
    always_comb begin
        h_d    = h_q;
        hcnt_d = h_last ? '0 : (pix_en_i ? hcnt_q + CNT_W'(1) : hcnt_q);
        if (!run_i) begin
            h_d    = H_IDLE;
            hcnt_d = '0;
        end else begin
            unique case (h_q)
                H_IDLE: begin
                    h_d    = H_SYNC;
                    hcnt_d = '0;
                end
                H_SYNC:   if (h_last) h_d = H_BACK;
                H_BACK:   if (h_last) h_d = H_ACTIVE;
                H_ACTIVE: if (h_last) h_d = H_FRONT;
                H_FRONT:  if (h_last) h_d = H_SYNC;
                default:  h_d = H_IDLE;
            endcase
        end
    end

    // Vertical next state, advanced at line ends only
    always_comb begin
        v_d    = v_q;
        vcnt_d = v_last ? '0 : (line_end ? vcnt_q + CNT_W'(1) : vcnt_q);
        if (!run_i) begin
            v_d    = V_IDLE;
            vcnt_d = '0;
        end else begin
            unique case (v_q)
                V_IDLE: begin
                    v_d    = V_SYNC;
                    vcnt_d = '0;
                end
                V_SYNC:   if (v_last) v_d = V_BACK;
                V_BACK:   if (v_last) v_d = V_ACTIVE;
                V_ACTIVE: if (v_last) v_d = V_FRONT;
                V_FRONT:  if (v_last) v_d = V_SYNC;
                default:  v_d = V_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q    <= H_IDLE;
            v_q    <= V_IDLE;
            hcnt_q <= '0;
            vcnt_q <= '0;
        end else begin
            h_q    <= h_d;
            v_q    <= v_d;
            hcnt_q <= hcnt_d;
            vcnt_q <= vcnt_d;
        end
    end

    assign hstate_o    = h_q;
    assign vstate_o    = v_q;
    assign hcnt_o      = hcnt_q;
    assign vcnt_o      = vcnt_q;
    assign scanning_o  = (h_q != H_IDLE);
    assign frame_end_o = v_last && (v_q == V_FRONT);

    assert_front_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && run_i) |=> (h_q == H_SYNC) && (hcnt_q == '0));

    assert_hold_between_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && h_q != H_IDLE && !pix_en_i) |=> ($stable(hcnt_q) && $stable(h_q)));

    assert_line_granular_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && v_q != V_IDLE && !line_end) |=> ($stable(vcnt_q) && $stable(v_q)));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (h_q == H_IDLE && v_q == V_IDLE && hcnt_q == '0 && vcnt_q == '0));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int PS_W    = 6,
    parameter int COL_W   = 24,
    parameter int NBANDS  = 8,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [CNT_W-1:0]  pix_x_o,
    output logic [CNT_W-1:0]  pix_y_o,
    output logic [COL_W-1:0]  pix_data_o
);

    localparam int BAND_IW = $clog2(NBANDS);

    logic [1:0]              mode;
    logic [3:0]              pol;
    logic [NBANDS*COL_W-1:0] colours;
    logic [CNT_W-1:0]        sh_hact, sh_hsw, sh_hbp, sh_hfp;
    logic [CNT_W-1:0]        sh_vact, sh_vsw, sh_vbp, sh_vfp;
    logic [PS_W-1:0]         sh_div;
    logic                    run, scanning, pix_en, frame_end, load;
    hstate_t                 hstate;
    vstate_t                 vstate;
    logic [CNT_W-1:0]        hcnt, vcnt;
    logic [BAND_IW-1:0]      band_q;
    logic [CNT_W-1:0]        bpos_q, band_w;
    logic                    hs_raw, vs_raw, h_act, v_act, de_raw;
    logic [COL_W-1:0]        data_raw;

    assign run  = (mode != MODE_OFF);
    assign load = !scanning || frame_end;

    lcdt_regs #(
        .CNT_W(CNT_W), .PS_W(PS_W), .COL_W(COL_W), .NBANDS(NBANDS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_i(load), .mode_o(mode), .pol_o(pol), .colours_o(colours),
        .sh_hact_o(sh_hact), .sh_hsw_o(sh_hsw), .sh_hbp_o(sh_hbp), .sh_hfp_o(sh_hfp),
        .sh_vact_o(sh_vact), .sh_vsw_o(sh_vsw), .sh_vbp_o(sh_vbp), .sh_vfp_o(sh_vfp),
        .sh_div_o(sh_div)
    );

    lcdt_prescale #(
        .PS_W(PS_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .run_i(run && scanning), .div_i(sh_div), .pix_en_o(pix_en)
    );

    lcdt_scan #(
        .CNT_W(CNT_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .run_i(run), .pix_en_i(pix_en),
        .hact_i(sh_hact), .hsw_i(sh_hsw), .hbp_i(sh_hbp), .hfp_i(sh_hfp),
        .vact_i(sh_vact), .vsw_i(sh_vsw), .vbp_i(sh_vbp), .vfp_i(sh_vfp),
        .hstate_o(hstate), .vstate_o(vstate), .hcnt_o(hcnt), .vcnt_o(vcnt),
        .scanning_o(scanning), .frame_end_o(frame_end)
    );

    // Band width: active width split into NBANDS, never narrower than one pixel
    assign band_w = ((sh_hact >> BAND_IW) == '0) ? CNT_W'(1) : (sh_hact >> BAND_IW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q <= '0;
            bpos_q <= '0;
        end else if (hstate != H_ACTIVE) begin
            band_q <= '0;
            bpos_q <= '0;
        end else if (pix_en) begin
            if (bpos_q == band_w - CNT_W'(1) && band_q != BAND_IW'(NBANDS - 1)) begin
                band_q <= band_q + BAND_IW'(1);
                bpos_q <= '0;
            end else begin
                bpos_q <= bpos_q + CNT_W'(1);
            end
        end
    end

    // Output decode
    always_comb begin
        hs_raw   = (hstate == H_SYNC);
        vs_raw   = (vstate == V_SYNC);
        h_act    = (hstate == H_ACTIVE);
        v_act    = (vstate == V_ACTIVE);
        de_raw   = h_act && v_act;
        data_raw = (de_raw && mode == MODE_BARS) ? colours[band_q*COL_W +: COL_W] : '0;

        hsync_o    = hs_raw ^ pol[POL_HS];
        vsync_o    = vs_raw ^ pol[POL_VS];
        de_o       = de_raw ^ pol[POL_DE];
        pix_data_o = data_raw ^ {COL_W{pol[POL_DATA]}};
        pix_x_o    = h_act ? hcnt : '0;
        pix_y_o    = v_act ? vcnt : '0;
    end

    assert_off_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && $past(mode == MODE_OFF)) |-> (!de_raw && !hs_raw && !vs_raw));

    assert_data_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !de_raw |-> (data_raw == '0));

endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk, rst_n, wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic        hsync_o, vsync_o, de_o;
    logic [11:0] pix_x_o, pix_y_o;
    logic [23:0] pix_data_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string phase   = "R6 reset";

    // model state
    int m_reg [0:31];
    bit idle;
    int pc, hp, vp;
    int s_hact, s_hsw, s_hbp, s_hfp, s_vact, s_vsw, s_vbp, s_vfp, s_div;

    lcd_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .pix_data_o(pix_data_o)
    );

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic check(input string tag, input longint got, input longint exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s (phase %s): got=%0h exp=%0h", tag, phase, got, exp);
        end
    endtask

    function automatic int lo1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int frame_clocks(input int d, input int ha, input int hs, input int hb,
                                        input int hf, input int va, input int vs, input int vb,
                                        input int vf);
        return d * (ha + hf + hs + hb) * (va + vf + vs + vb);
    endfunction

    task automatic latch_shadow();
        s_hact = lo1(m_reg[1]); s_hsw = lo1(m_reg[2]); s_hbp = lo1(m_reg[3]);
        s_hfp  = lo1(m_reg[4]); s_vact = lo1(m_reg[5]); s_vsw = lo1(m_reg[6]);
        s_vbp  = lo1(m_reg[7]); s_vfp = lo1(m_reg[8]);
        s_div  = (m_reg[9] < 2) ? 2 : ((m_reg[9] > 32) ? 32 : m_reg[9]);
    endtask

    // Reference model: linear positions within line and frame
    always @(posedge clk) begin
        if (!rst_n) begin
            idle = 1; pc = 0; hp = 0; vp = 0;
            for (int i = 0; i < 32; i++) m_reg[i] = 0;
            latch_shadow();
        end else begin
            if (m_reg[0] == 0) begin
                idle = 1; pc = 0; hp = 0; vp = 0;
            end else if (idle) begin
                idle = 0; pc = 0; hp = 0; vp = 0;
                latch_shadow();
            end else if (pc == s_div - 1) begin
                pc = 0;
                hp++;
                if (hp == s_hsw + s_hbp + s_hact + s_hfp) begin
                    hp = 0;
                    vp++;
                    if (vp == s_vsw + s_vbp + s_vact + s_vfp) begin
                        vp = 0;
                        latch_shadow();
                    end
                end
            end else begin
                pc++;
            end
            if (wr_en) begin
                case (wr_addr)
                    0:       m_reg[0] = wr_data & 32'h3;
                    9:       m_reg[9] = wr_data & 32'h3F;
                    10:      m_reg[10] = wr_data & 32'hF;
                    default: begin
                        if (wr_addr >= 16 && wr_addr < 24) m_reg[wr_addr] = wr_data & 32'hFFFFFF;
                        else if (wr_addr >= 1 && wr_addr <= 8) m_reg[wr_addr] = wr_data & 32'hFFF;
                    end
                endcase
            end
        end
    end

    // Every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_hs, e_vs, e_de, e_x, e_y, e_data, bw, idx;
            bit ha, va;
            e_hs = 0; e_vs = 0; e_de = 0; e_x = 0; e_y = 0; e_data = 0;
            if (!idle) begin
                e_hs = (hp < s_hsw) ? 1 : 0;
                e_vs = (vp < s_vsw) ? 1 : 0;
                ha = (hp >= s_hsw + s_hbp) && (hp < s_hsw + s_hbp + s_hact);
                va = (vp >= s_vsw + s_vbp) && (vp < s_vsw + s_vbp + s_vact);
                e_de = (ha && va) ? 1 : 0;
                e_x = ha ? hp - (s_hsw + s_hbp) : 0;
                e_y = va ? vp - (s_vsw + s_vbp) : 0;
                if (e_de == 1 && m_reg[0] == 3) begin
                    bw = (s_hact / 8 == 0) ? 1 : s_hact / 8;
                    idx = e_x / bw;
                    if (idx > 7) idx = 7;
                    e_data = m_reg[16 + idx];
                end
            end
            if (m_reg[10][0]) e_hs = 1 - e_hs;
            if (m_reg[10][1]) e_vs = 1 - e_vs;
            if (m_reg[10][2]) e_de = 1 - e_de;
            if (m_reg[10][3]) e_data = e_data ^ 32'hFFFFFF;
            check("R1 hsync", hsync_o, e_hs);
            check("R2 vsync", vsync_o, e_vs);
            check("R1 de", de_o, e_de);
            check("R9 x", pix_x_o, e_x);
            check("R9 y", pix_y_o, e_y);
            check("R7 data", pix_data_o, e_data);
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = 5'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic count_to_rise(inout int n);
        logic prev;
        do begin
            prev = vsync_o;
            @(negedge clk);
            n++;
        end while (!(prev == 1'b0 && vsync_o == 1'b1));
    endtask

    task automatic wait_rise();
        int dummy = 0;
        count_to_rise(dummy);
    endtask

    task automatic measure(output int n);
        wait_rise();
        n = 0;
        count_to_rise(n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R4 watchdog: got=timeout exp=completion");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R6 reset hsync", hsync_o, 0);
        check("R6 reset vsync", vsync_o, 0);
        check("R6 reset de", de_o, 0);
        check("R6 reset data", pix_data_o, 0);

        // Basic timing in mode 01 (data 0)
        phase = "R1 R2 R4 basic";
        wr(1, 16); wr(2, 2); wr(3, 3); wr(4, 2);
        wr(5, 4);  wr(6, 1); wr(7, 1); wr(8, 1);
        wr(9, 2);  wr(0, 1);
        measure(n);
        check("R4 frame length", n, frame_clocks(2, 16, 2, 3, 2, 4, 1, 1, 1));

        // Colour bars, width 20: band width 2, band 7 takes 6 pixels
        phase = "R7 bars";
        for (int k = 0; k < 8; k++) wr(16 + k, 32'h0A0B0C + k * 32'h111111);
        wr(1, 20); wr(9, 3); wr(0, 3);
        measure(n);
        check("R4 frame length div3", n, frame_clocks(3, 20, 2, 3, 2, 4, 1, 1, 1));
        while (!(de_o && pix_x_o == 12'd19)) @(negedge clk);
        check("R7 leftover pixel in band 7", pix_data_o, 32'h0A0B0C + 7 * 32'h111111);

        // Zero porches and prescale below range
        phase = "R3 clamp";
        wr(3, 0); wr(4, 0); wr(7, 0); wr(8, 0); wr(9, 1);
        wait_rise();
        measure(n);
        check("R3 zero porches act as one", n, frame_clocks(2, 20, 2, 1, 1, 4, 1, 1, 1));

        phase = "R4 prescale ceiling";
        wr(9, 40);
        wait_rise();
        measure(n);
        check("R4 prescale clamped to 32", n, frame_clocks(32, 20, 2, 1, 1, 4, 1, 1, 1));

        // Inverted polarity on every output
        phase = "R5 polarity";
        wr(9, 2); wr(10, 15);
        repeat (800) @(negedge clk);

        phase = "R6 off";
        wr(0, 0);
        repeat (2) @(negedge clk);
        check("R6 off hsync inactive", hsync_o, 1);
        check("R6 off vsync inactive", vsync_o, 1);
        check("R6 off de inactive", de_o, 1);
        check("R6 off data inactive", pix_data_o, 24'hFFFFFF);
        check("R6 off x", pix_x_o, 0);
        check("R6 off y", pix_y_o, 0);
        repeat (20) @(negedge clk);
        wr(10, 0);

        // Mid-frame write must not disturb the current frame
        phase = "R8 shadow";
        wr(0, 1);
        wait_rise();
        n = 0;
        repeat (50) begin
            @(negedge clk);
            n++;
        end
        wr(1, 8);
        n++;
        count_to_rise(n);
        check("R8 frame in progress keeps old width", n, frame_clocks(2, 20, 2, 1, 1, 4, 1, 1, 1));
        n = 0;
        count_to_rise(n);
        check("R8 next frame uses new width", n, frame_clocks(2, 8, 2, 1, 1, 4, 1, 1, 1));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule